// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner collects a large set of level-sensitive interrupt sources, arranged as 32 groups of 8, and reduces each group to a single interrupt line for a downstream interrupt controller. Each source has its own enable bit. A group line is raised while any enabled source in that group is high. Software sees the sources through a 32-bit word-addressed register port. The port offers raw levels, levels filtered by the enables, and one word with a pending flag per group.

The 256 sources are packed four groups to a 32-bit word, one byte lane per group, and the eight such words form banks. Enable bits are never written directly. Software writes ones to a set register or to a clear register, so two agents can change different sources without a read-modify-write race. A handler reads the pending word, picks a group, and reads that group's bank to find the active sources.

Top module: `grouped_irq_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group line `grp_irq_o` is 0, and `reg_rdata_o` is 0.
- R2: Source b of group g is input bit `src_i[g*8+b]`. Its bank is n = g/4, at byte offset 0x10*n, and its bit inside that bank's registers is (g mod 4)*8+b. Register slots within a bank: +0x0 enable-set, +0x4 enable-clear, +0x8 raw status, +0xC masked status.
- R3: A write to an enable-set register enables each source whose data bit is 1 and leaves the others unchanged.
- R4: A write to an enable-clear register disables each source whose data bit is 1 and leaves the others unchanged.
- R5: A read of either the enable-set or the enable-clear register of a bank returns that bank's current enable mask.
- R6: Raw status returns the current source levels of the bank. Masked status returns raw status ANDed with the enable mask.
- R7: The word at offset 0x100 holds one pending bit per group, bit g set when any masked status bit of group g is 1.
- R8: `grp_irq_o[g]` is a registered OR of group g's masked sources. It follows a source or enable change one clock later and stays 0 while no enabled source is high.
- R9: Reads have one cycle of latency: data for a read presented at clock edge k appears after edge k and is held until edge k+1. In a cycle after no read, `reg_rdata_o` is 0.
- R10: Unmapped offsets (0x80 to 0xFC, above 0x100, or not a multiple of 4) read as 0 and ignore writes. Writes to status and pending registers change no enable bit.
- R11: Enable bits hold their value in every cycle without an enable-set or enable-clear write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 256 | Level interrupt sources, bit g*8+b is source b of group g |
| reg_addr_i | input | 12 | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| grp_irq_o | output | 32 | One combined interrupt line per group |

## Verification
Directed patterns come first: a single source in one byte lane shows whether lane and bank placement are right, and set/clear writes with mixed zero bits show that untouched enables survive. Writes of ones to status, pending and unmapped addresses show that they leave the enables alone. Random source levels paired with random set and clear writes to random banks then exercise the masking. Random reads of every mapped slot are compared with a bench model of enables and levels, and the group lines are compared against the same model one clock later. The random cases separate a wrong AND, a wrong group reduction and a wrong bank select.

// File: rtl/gic_pkg.sv
package gic_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_SET,
    K_CLR,
    K_RAW,
    K_MSK,
    K_PEND
  } reg_kind_e;

  // Register slot inside a bank window, from address bits [3:2]
  function automatic reg_kind_e slot_kind(input logic [1:0] slot);
    case (slot)
      2'd0:    return K_SET;
      2'd1:    return K_CLR;
      2'd2:    return K_RAW;
      default: return K_MSK;
    endcase
  endfunction

  // One when any bit of a group's byte is set
  function automatic logic lane_any(input logic [7:0] lane);
    return |lane;
  endfunction

endpackage

// File: rtl/combiner_regdec.sv
module combiner_regdec
  import gic_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_BANKS = 8,
  parameter int PEND_OFS  = 256,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  output reg_kind_e         kind_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [NUM_BANKS-1:0] set_we_o,
  output logic [NUM_BANKS-1:0] clr_we_o
);
  localparam logic [ADDR_W-5:0] NB_LIM = (ADDR_W-4)'(NUM_BANKS);
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(PEND_OFS);

  logic [ADDR_W-5:0] win;
  logic              aligned;
  logic              in_banks;
  logic              pend_hit;

  assign win      = addr_i[ADDR_W-1:4];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_banks = aligned && (win < NB_LIM);
  assign pend_hit = aligned && (addr_i == PEND_A);
  assign bank_o   = win[BANK_W-1:0];

  always_comb begin
    if (in_banks)      kind_o = slot_kind(addr_i[3:2]);
    else if (pend_hit) kind_o = K_PEND;
    else               kind_o = K_NONE;
  end

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_we
    assign set_we_o[n] = wr_i && (kind_o == K_SET) && (bank_o == BANK_W'(n));
    assign clr_we_o[n] = wr_i && (kind_o == K_CLR) && (bank_o == BANK_W'(n));
  end

endmodule

// File: rtl/combiner_enable_bank.sv
module combiner_enable_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= '0;
    else if (set_we_i) en_q <= en_q | wdata_i;
    else if (clr_we_i) en_q <= en_q & ~wdata_i;
  end

  // R3: ones written to the set register are enabled afterwards
  a_r3_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
    set_we_i |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  // R4: ones written to the clear register are disabled afterwards
  a_r4_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((en_q & $past(wdata_i)) == '0));

  // R3/R4: zero bits of either write are left alone
  a_r3_zero_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we_i || clr_we_i) |=> ((en_q & ~$past(wdata_i)) == ($past(en_q) & ~$past(wdata_i))));

  // R11: no write, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we_i && !clr_we_i) |=> $stable(en_q));

endmodule

// File: rtl/combiner_group_or.sv
module combiner_group_or
  import gic_pkg::*;
#(
  parameter int NUM_GROUPS    = 32,
  parameter int SRC_PER_GROUP = 8
) (
  input  logic [NUM_GROUPS*SRC_PER_GROUP-1:0] masked_i,
  output logic [NUM_GROUPS-1:0]               any_o
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic [7:0] lane;
    assign lane     = 8'(masked_i[g*SRC_PER_GROUP +: SRC_PER_GROUP]);
    assign any_o[g] = lane_any(lane);
  end
endmodule

// File: rtl/grouped_irq_combiner.sv
module grouped_irq_combiner
  import gic_pkg::*;
#(
  parameter int NUM_GROUPS    = 32,
  parameter int SRC_PER_GROUP = 8,
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 12,
  parameter int PEND_OFS      = 256,
  localparam int NSRC         = NUM_GROUPS * SRC_PER_GROUP,
  localparam int GRP_PER_BANK = DATA_W / SRC_PER_GROUP,
  localparam int NUM_BANKS    = NUM_GROUPS / GRP_PER_BANK,
  localparam int BANK_W       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NUM_GROUPS-1:0] grp_irq_o
);

  reg_kind_e          kind;
  logic [BANK_W-1:0]  bank;
  logic [NUM_BANKS-1:0] set_we;
  logic [NUM_BANKS-1:0] clr_we;
  logic [NSRC-1:0]    en_all;
  logic [NSRC-1:0]    masked;
  logic [NUM_GROUPS-1:0] grp_any;
  logic [DATA_W-1:0]  rd_val;

  combiner_regdec #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .PEND_OFS(PEND_OFS)
  ) u_dec (
    .addr_i(reg_addr_i), .wr_i(reg_wr_i), .kind_o(kind), .bank_o(bank),
    .set_we_o(set_we), .clr_we_o(clr_we)
  );

  for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
    combiner_enable_bank #(.W(DATA_W)) u_en (
      .clk(clk), .rst_n(rst_n), .set_we_i(set_we[n]), .clr_we_i(clr_we[n]),
      .wdata_i(reg_wdata_i), .en_q(en_all[n*DATA_W +: DATA_W])
    );
  end

  assign masked = src_i & en_all;

  combiner_group_or #(
    .NUM_GROUPS(NUM_GROUPS), .SRC_PER_GROUP(SRC_PER_GROUP)
  ) u_or (
    .masked_i(masked), .any_o(grp_any)
  );

  always_comb begin
    rd_val = '0;
    case (kind)
      K_SET, K_CLR: rd_val = en_all[bank*DATA_W +: DATA_W];
      K_RAW:        rd_val = src_i[bank*DATA_W +: DATA_W];
      K_MSK:        rd_val = masked[bank*DATA_W +: DATA_W];
      K_PEND:       rd_val[NUM_GROUPS-1:0] = grp_any;
      default:      rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata_o <= '0;
      grp_irq_o   <= '0;
    end else begin
      reg_rdata_o <= reg_rd_i ? rd_val : '0;
      grp_irq_o   <= grp_any;
    end
  end

  // R8: no enabled source means quiet lines on the next cycle
  a_r8_quiet_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |=> (grp_irq_o == '0));
  a_r8_quiet_without_source: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |=> (grp_irq_o == '0));

  // R9: no read, zero data next cycle
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> (reg_rdata_o == '0));

  // R10: unmapped reads return zero, non-enable writes keep enables
  a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && kind == K_NONE) |=> (reg_rdata_o == '0));
  a_r10_other_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && kind != K_SET && kind != K_CLR) |=> $stable(en_all));

endmodule

// File: tb/grouped_irq_combiner_bench.sv
module grouped_irq_combiner_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] src_i = '0;
  logic [11:0]  reg_addr_i = '0;
  logic         reg_wr_i = 1'b0;
  logic         reg_rd_i = 1'b0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic [31:0]  grp_irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] en_m [8];

  always #4 clk = ~clk;

  grouped_irq_combiner u_grouped_irq_combiner (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .grp_irq_o(grp_irq_o)
  );

  function automatic logic [31:0] bank_raw(input int n);
    return src_i[n*32 +: 32];
  endfunction

  function automatic logic [31:0] pend_model();
    logic [31:0] p = '0;
    for (int g = 0; g < 32; g++) begin
      logic [31:0] m = bank_raw(g / 4) & en_m[g / 4];
      p[g] = (m[(g % 4) * 8 +: 8] != 8'h00);
    end
    return p;
  endfunction

  function automatic logic [31:0] read_model(input logic [11:0] a);
    if (a[1:0] != 2'b00) return '0;
    if (a < 12'h080) begin
      case (a[3:2])
        2'd0, 2'd1: return en_m[a[6:4]];
        2'd2:       return bank_raw(a[6:4]);
        default:    return bank_raw(a[6:4]) & en_m[a[6:4]];
      endcase
    end
    if (a == 12'h100) return pend_model();
    return '0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    if (a[1:0] == 2'b00 && a < 12'h080) begin
      if (a[3:2] == 2'd0) en_m[a[6:4]] = en_m[a[6:4]] | d;
      if (a[3:2] == 2'd1) en_m[a[6:4]] = en_m[a[6:4]] & ~d;
    end
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input string req, input logic [11:0] a);
    logic [31:0] exp;
    @(negedge clk);
    reg_addr_i = a; reg_rd_i = 1'b1;
    exp = read_model(a);
    @(negedge clk);
    reg_rd_i = 1'b0;
    check(req, reg_rdata_o, exp);
  endtask

  task automatic check_irq(input string req);
    @(negedge clk);
    check(req, grp_irq_o, pend_model());
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 8; i++) en_m[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", grp_irq_o, 32'h0);
    check("R1 rdata", reg_rdata_o, 32'h0);
    rst_n = 1'b1;
    reg_read("R1 enables bank0", 12'h000);
    reg_read("R1 enables bank7", 12'h074);

    // R2: group 13 (bank 3, lane 1), source 5 -> bit 13 of bank 3
    src_i[13*8 + 5] = 1'b1;
    reg_read("R2 raw lane", 12'h038);
    check("R2 raw bit", reg_rdata_o, 32'h0000_2000);
    reg_write(12'h030, 32'h0000_2000);
    reg_read("R2 masked lane", 12'h03C);
    check_irq("R8 group13");
    check("R8 group13 bit", grp_irq_o, 32'h0000_2000);
    reg_read("R7 pending", 12'h100);

    // R3: zero bits keep enables
    reg_write(12'h030, 32'h0100_0000);
    reg_read("R3 set keeps others", 12'h030);
    check("R3 set value", reg_rdata_o, 32'h0100_2000);
    // R4: clear only ones
    reg_write(12'h034, 32'h0100_0000);
    reg_read("R5 read via clear slot", 12'h034);
    check("R4 clear value", reg_rdata_o, 32'h0000_2000);
    reg_write(12'h034, 32'h0000_0000);
    reg_read("R4 zero clear no effect", 12'h030);

    // R10: writes that must not touch enables
    reg_write(12'h038, 32'hFFFF_FFFF);
    reg_write(12'h03C, 32'hFFFF_FFFF);
    reg_write(12'h100, 32'hFFFF_FFFF);
    reg_write(12'h080, 32'hFFFF_FFFF);
    reg_write(12'h032, 32'hFFFF_FFFF);
    reg_read("R10 enables intact", 12'h030);
    check("R10 enables value", reg_rdata_o, 32'h0000_2000);
    reg_read("R10 unmapped 0x80", 12'h080);
    reg_read("R10 unmapped 0x104", 12'h104);
    reg_read("R10 misaligned", 12'h03A);
    reg_read("R10 unmapped high", 12'hFFC);

    // R8: disable clears the line one cycle later
    reg_write(12'h034, 32'h0000_2000);
    check_irq("R8 disabled");
    // R9: no read -> zero data
    @(negedge clk);
    check("R9 idle rdata", reg_rdata_o, 32'h0);

    // Random phase
    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        for (int w = 0; w < 8; w++) src_i[w*32 +: 32] = $urandom() & $urandom();
      end
      case (op)
        0: reg_write({5'b0, 3'($urandom_range(0, 7)), 4'h0}, $urandom());
        1: reg_write({5'b0, 3'($urandom_range(0, 7)), 4'h4}, $urandom());
        2: begin
          if ($urandom_range(0, 4) == 0) reg_read("R7 random pending", 12'h100);
          else reg_read("R6 random bank read",
                        {5'b0, 3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 2'b00});
        end
        default: reg_write(12'($urandom_range(0, 4095)), $urandom());
      endcase
      check_irq("R8 random lines");
      if (it % 50 == 0) begin
        @(negedge clk);
        check("R11 idle hold rdata", reg_rdata_o, 32'h0);
        reg_read("R11 enables held", {5'b0, 3'(it % 8), 4'h0});
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule